// File: doc/BRIEF.md
# PCI Bus Parity Checker and Error Reporter

This block watches a PCI agent's shared bus and checks the parity of every address phase and every completed data phase. The address/data and command/byte-enable lines are latched on the phase clock. They are then compared, one clock later, against the parity bit that the bus delivers in that following clock. A failing data phase produces a one-clock active-low pulse on the data parity error output. A failing address phase produces a one-clock pulse on the output enable of an open-drain, active-low system error line. Each output is gated by its own command-register enable bit.

The upper 32-bit lane and its parity bit are checked only while a 64-bit transfer is in progress. A small width-tracking state machine decides this from the 64-bit request and acknowledge handshakes. Its states are `XW_IDLE`, `XW_PENDING`, `XW_NARROW` and `XW_WIDE`, with these transitions:

- An address phase with the 64-bit request low moves the machine to `XW_PENDING`.
- An address phase with the request high moves it to `XW_NARROW`.
- `XW_PENDING` resolves on the first clock that device select is low. It goes to `XW_WIDE` if the 64-bit acknowledge is also low, and to `XW_NARROW` otherwise.
- Any state returns to `XW_IDLE` on a clock where frame and initiator-ready are both high.
- An address phase restarts the machine from any state.

When the 64-bit build option is off, the upper lane is never checked. A sticky status flag records every detected error, and a write-one-to-clear strobe clears it.

Top module: `pci_parity_guard`

## Requirements
- R1: While the synchronous active-low reset is held, `dperr_n` reads 1, `serr_oe` reads 0 and `parity_err_flag` reads 0. A pulse already in the pipeline is discarded by reset.
- R2: Parity is even. The lower lane is correct when AD[31:0], C/BE[3:0] and `par_lo` together hold an even number of ones. A correct phase produces no error output.
- R3: A data phase in clock P with a lower-lane parity error drives `dperr_n` low in clock P+2 only, where `par_lo` arrives in clock P+1. Consecutive failing phases give consecutive low clocks.
- R4: `dperr_n` is driven low only when `cmd_perr_resp` (command bit 6) is 1 in the clock that the parity bit arrives.
- R5: An address phase in clock P with a lower-lane parity error raises `serr_oe` in clock P+2 only, and only if `cmd_serr_en` (command bit 8) is 1. An address phase never drives `dperr_n`.
- R6: A clock is checked as a data phase only when `irdy_n` and `trdy_n` are both low. Wait-state clocks with bad parity produce no output.
- R7: During a 64-bit transfer, an even-parity error over AD[63:32], C/BE[7:4] and `par_hi` is reported on `dperr_n` like a lower-lane error. A transfer is 64-bit when `req64_n` was low in its address phase and `ack64_n` is low when `devsel_n` first goes low.
- R8: In a transfer whose address phase had `req64_n` high, or whose target answered with `ack64_n` high, the upper lane and `par_hi` have no effect.
- R9: `parity_err_flag` is set in clock P+2 by any detected address or data parity error, whatever the enables. It stays set until a clock with `status_clr` high and no new error; a new error wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_phase | input | 1 | High in the clock of an address phase |
| frame_n | input | 1 | Frame, active low |
| req64_n | input | 1 | 64-bit request, timed like frame |
| devsel_n | input | 1 | Device select, active low |
| ack64_n | input | 1 | 64-bit acknowledge, timed like device select |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| ad | input | 64 | Address/data lines |
| cbe | input | 8 | Command/byte-enable lines |
| par_lo | input | 1 | Even parity of the lower lane, one clock late |
| par_hi | input | 1 | Even parity of the upper lane, one clock late |
| cmd_perr_resp | input | 1 | Command register bit 6, parity error response enable |
| cmd_serr_en | input | 1 | Command register bit 8, system error enable |
| status_clr | input | 1 | Write-one-to-clear strobe for the sticky flag |
| dperr_n | output | 1 | Data parity error, active low |
| serr_oe | output | 1 | Pull-low enable of the open-drain system error line |
| parity_err_flag | output | 1 | Sticky detected-parity-error status |

## Verification
Every phase the bench drives in clock P has its error result due in clock P+2. The one-clock gap to the parity bit and the one output register account for those two clocks. The sticky flag changes in that same clock, or one clock after a clear strobe. The driver stamps each expected item with the clock count P+2. The monitor compares the outputs in that clock and expects both outputs idle in every other clock. All sampling happens on the falling edge, half a period away from the edges that move the outputs.

// File: rtl/pcipar_pkg.sv
package pcipar_pkg;

    typedef enum logic [1:0] {
        XW_IDLE,
        XW_PENDING,
        XW_NARROW,
        XW_WIDE
    } xw_state_e;

    typedef enum logic [1:0] {
        PH_NONE,
        PH_ADDR,
        PH_DATA
    } phase_e;

endpackage

// File: rtl/pcipar_width_fsm.sv
module pcipar_width_fsm
    import pcipar_pkg::*;
#(
    parameter bit ENABLE_64 = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_phase,
    input  logic frame_n,
    input  logic req64_n,
    input  logic devsel_n,
    input  logic ack64_n,
    input  logic irdy_n,
    output logic wide_now
);

    xw_state_e st_q;
    xw_state_e st_d;
    logic      bus_idle;

    assign bus_idle = frame_n && irdy_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= XW_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        if (addr_phase) begin
            st_d = (req64_n || !ENABLE_64) ? XW_NARROW : XW_PENDING;
        end else begin
            unique case (st_q)
                XW_IDLE: st_d = XW_IDLE;
                XW_PENDING: begin
                    if (bus_idle) begin
                        st_d = XW_IDLE;
                    end else if (!devsel_n) begin
                        st_d = ack64_n ? XW_NARROW : XW_WIDE;
                    end
                end
                XW_NARROW, XW_WIDE: begin
                    if (bus_idle) begin
                        st_d = XW_IDLE;
                    end
                end
                default: st_d = XW_IDLE;
            endcase
        end
    end

    always_comb begin
        wide_now = 1'b0;
        if (ENABLE_64 && !addr_phase) begin
            unique case (st_q)
                XW_WIDE:    wide_now = 1'b1;
                XW_PENDING: wide_now = !devsel_n && !ack64_n;
                default:    wide_now = 1'b0;
            endcase
        end
    end

    // R8
    narrow_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase && req64_n |=> st_q == XW_NARROW);

    // R8
    narrow_on_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == XW_PENDING && !addr_phase && !devsel_n && ack64_n && !(frame_n && irdy_n)
        |=> st_q == XW_NARROW);

endmodule

// File: rtl/pcipar_capture.sv
module pcipar_capture
    import pcipar_pkg::*;
#(
    parameter int LANE_W  = 32,
    parameter int LANE_BE = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   addr_phase,
    input  logic                   irdy_n,
    input  logic                   trdy_n,
    input  logic                   wide_now,
    input  logic [2*LANE_W-1:0]    ad,
    input  logic [2*LANE_BE-1:0]   cbe,
    output phase_e                 kind_q,
    output logic                   wide_q,
    output logic [2*LANE_W-1:0]    ad_q,
    output logic [2*LANE_BE-1:0]   cbe_q
);

    phase_e kind_d;

    always_comb begin
        if (addr_phase) begin
            kind_d = PH_ADDR;
        end else if (!irdy_n && !trdy_n) begin
            kind_d = PH_DATA;
        end else begin
            kind_d = PH_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= PH_NONE;
            wide_q <= 1'b0;
            ad_q   <= '0;
            cbe_q  <= '0;
        end else begin
            kind_q <= kind_d;
            wide_q <= wide_now && (kind_d == PH_DATA);
            ad_q   <= ad;
            cbe_q  <= cbe;
        end
    end

    // R6
    data_needs_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kind_q == PH_DATA |-> $past(!irdy_n) && $past(!trdy_n));

endmodule

// File: rtl/pcipar_lane_check.sv
module pcipar_lane_check #(
    parameter int LANE_W  = 32,
    parameter int LANE_BE = 4,
    parameter int LANES   = 2
) (
    input  logic [LANES*LANE_W-1:0]  ad,
    input  logic [LANES*LANE_BE-1:0] cbe,
    input  logic [LANES-1:0]         par,
    output logic [LANES-1:0]         lane_bad
);

    for (genvar li = 0; li < LANES; li++) begin : g_lane
        assign lane_bad[li] = ^{ad[li*LANE_W +: LANE_W], cbe[li*LANE_BE +: LANE_BE], par[li]};
    end

endmodule

// File: rtl/pcipar_report.sv
module pcipar_report
    import pcipar_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_e           kind_q,
    input  logic             wide_q,
    input  logic [LANES-1:0] lane_bad,
    input  logic             perr_en,
    input  logic             serr_en,
    input  logic             status_clr,
    output logic             dperr_n,
    output logic             serr_oe,
    output logic             flag
);

    logic hi_bad;
    logic data_hit;
    logic addr_hit;

    if (LANES > 1) begin : g_hi
        assign hi_bad = lane_bad[LANES-1];
    end else begin : g_no_hi
        assign hi_bad = 1'b0;
    end

    assign data_hit = (kind_q == PH_DATA) && (lane_bad[0] || (wide_q && hi_bad));
    assign addr_hit = (kind_q == PH_ADDR) && lane_bad[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dperr_n <= 1'b1;
            serr_oe <= 1'b0;
            flag    <= 1'b0;
        end else begin
            dperr_n <= !(data_hit && perr_en);
            serr_oe <= addr_hit && serr_en;
            if (data_hit || addr_hit) begin
                flag <= 1'b1;
            end else if (status_clr) begin
                flag <= 1'b0;
            end
        end
    end

    // R4
    perr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dperr_n |-> $past(perr_en));

    // R5
    serr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_oe |-> $past(serr_en));

    // R5
    single_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!dperr_n, serr_oe}));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !status_clr |=> flag);

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dperr_n || serr_oe |-> flag);

endmodule

// File: rtl/pci_parity_guard.sv
module pci_parity_guard
    import pcipar_pkg::*;
#(
    parameter int LANE_W    = 32,
    parameter int LANE_BE   = 4,
    parameter bit ENABLE_64 = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 addr_phase,
    input  logic                 frame_n,
    input  logic                 req64_n,
    input  logic                 devsel_n,
    input  logic                 ack64_n,
    input  logic                 irdy_n,
    input  logic                 trdy_n,
    input  logic [2*LANE_W-1:0]  ad,
    input  logic [2*LANE_BE-1:0] cbe,
    input  logic                 par_lo,
    input  logic                 par_hi,
    input  logic                 cmd_perr_resp,
    input  logic                 cmd_serr_en,
    input  logic                 status_clr,
    output logic                 dperr_n,
    output logic                 serr_oe,
    output logic                 parity_err_flag
);

    localparam int LANES = ENABLE_64 ? 2 : 1;

    logic                 wide_now;
    phase_e               kind_q;
    logic                 wide_q;
    logic [2*LANE_W-1:0]  ad_q;
    logic [2*LANE_BE-1:0] cbe_q;
    logic [1:0]           par_vec;
    logic [LANES-1:0]     lane_bad;

    assign par_vec = {par_hi, par_lo};

    pcipar_width_fsm #(
        .ENABLE_64 (ENABLE_64)
    ) u_width (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_phase (addr_phase),
        .frame_n    (frame_n),
        .req64_n    (req64_n),
        .devsel_n   (devsel_n),
        .ack64_n    (ack64_n),
        .irdy_n     (irdy_n),
        .wide_now   (wide_now)
    );

    pcipar_capture #(
        .LANE_W  (LANE_W),
        .LANE_BE (LANE_BE)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_phase (addr_phase),
        .irdy_n     (irdy_n),
        .trdy_n     (trdy_n),
        .wide_now   (wide_now),
        .ad         (ad),
        .cbe        (cbe),
        .kind_q     (kind_q),
        .wide_q     (wide_q),
        .ad_q       (ad_q),
        .cbe_q      (cbe_q)
    );

    pcipar_lane_check #(
        .LANE_W  (LANE_W),
        .LANE_BE (LANE_BE),
        .LANES   (LANES)
    ) u_lanes (
        .ad       (ad_q[LANES*LANE_W-1:0]),
        .cbe      (cbe_q[LANES*LANE_BE-1:0]),
        .par      (par_vec[LANES-1:0]),
        .lane_bad (lane_bad)
    );

    pcipar_report #(
        .LANES (LANES)
    ) u_report (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind_q     (kind_q),
        .wide_q     (wide_q),
        .lane_bad   (lane_bad),
        .perr_en    (cmd_perr_resp),
        .serr_en    (cmd_serr_en),
        .status_clr (status_clr),
        .dperr_n    (dperr_n),
        .serr_oe    (serr_oe),
        .flag       (parity_err_flag)
    );

    // R3
    perr_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dperr_n |-> $past(!irdy_n, 2) && $past(!trdy_n, 2));

    // R5
    serr_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_oe |-> $past(addr_phase, 2));

endmodule

// File: tb/pci_parity_guard_bench.sv
module pci_parity_guard_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        int    due;
        bit    dperr;
        bit    serr;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_phase = 1'b0;
    logic        frame_n = 1'b1;
    logic        req64_n = 1'b1;
    logic        devsel_n = 1'b1;
    logic        ack64_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        trdy_n = 1'b1;
    logic [63:0] ad = '0;
    logic [7:0]  cbe = '0;
    logic        par_lo = 1'b0;
    logic        par_hi = 1'b0;
    logic        cmd_perr_resp = 1'b1;
    logic        cmd_serr_en = 1'b1;
    logic        status_clr = 1'b0;
    logic        dperr_n;
    logic        serr_oe;
    logic        parity_err_flag;

    exp_t sbq[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   mon_en = 1'b0;
    logic nxt_lo = 1'b0;
    logic nxt_hi = 1'b0;

    pci_parity_guard u_pci_parity_guard (
        .clk             (clk),
        .rst_n           (rst_n),
        .addr_phase      (addr_phase),
        .frame_n         (frame_n),
        .req64_n         (req64_n),
        .devsel_n        (devsel_n),
        .ack64_n         (ack64_n),
        .irdy_n          (irdy_n),
        .trdy_n          (trdy_n),
        .ad              (ad),
        .cbe             (cbe),
        .par_lo          (par_lo),
        .par_hi          (par_hi),
        .cmd_perr_resp   (cmd_perr_resp),
        .cmd_serr_en     (cmd_serr_en),
        .status_clr      (status_clr),
        .dperr_n         (dperr_n),
        .serr_oe         (serr_oe),
        .parity_err_flag (parity_err_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Driver: one bus clock; drives parity owed by the previous clock and
    // queues the result due two clocks later.
    task automatic tick(input bit ap, input bit r64n, input bit frn, input bit dvn,
                        input bit a64n, input bit irn, input bit trn,
                        input logic [63:0] a, input logic [7:0] b,
                        input bit flip_lo, input bit flip_hi, input bit exp_wide,
                        input string tag);
        exp_t e;
        bit   dph;
        @(negedge clk);
        par_lo     = nxt_lo;
        par_hi     = nxt_hi;
        addr_phase = ap;
        req64_n    = r64n;
        frame_n    = frn;
        devsel_n   = dvn;
        ack64_n    = a64n;
        irdy_n     = irn;
        trdy_n     = trn;
        ad         = a;
        cbe        = b;
        nxt_lo     = (^{a[31:0], b[3:0]}) ^ flip_lo;
        nxt_hi     = (^{a[63:32], b[7:4]}) ^ flip_hi;
        dph        = !ap && !irn && !trn;
        if (ap || !irn || !trn) begin
            e.due   = cyc + 2;
            e.dperr = dph && (flip_lo || (exp_wide && flip_hi)) && cmd_perr_resp;
            e.serr  = ap && flip_lo && cmd_serr_en;
            e.req   = tag;
            sbq.push_back(e);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            tick(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 64'h0, 8'h0,
                 1'b0, 1'b0, 1'b0, "R3");
        end
    endtask

    task automatic expect_bit(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", what, act, exp);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk);
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
        expect_bit(parity_err_flag, 1'b0, "R9 flag after clear");
    endtask

    // Monitor: pops the item due this clock; otherwise both outputs idle.
    always @(negedge clk) begin : mon
        bit    ed;
        bit    es;
        string tg;
        if (mon_en) begin
            ed = 1'b0;
            es = 1'b0;
            tg = "R3 quiet clock";
            if (sbq.size() > 0 && sbq[0].due == cyc) begin
                ed = sbq[0].dperr;
                es = sbq[0].serr;
                tg = sbq[0].req;
                void'(sbq.pop_front());
            end
            checks++;
            if (dperr_n !== !ed || serr_oe !== es) begin
                errors++;
                $display("FAIL %s at clock %0d: dperr_n=%b serr_oe=%b expected dperr_n=%b serr_oe=%b",
                         tg, cyc, dperr_n, serr_oe, !ed, es);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        expect_bit(dperr_n, 1'b1, "R1 dperr_n in reset");
        expect_bit(serr_oe, 1'b0, "R1 serr_oe in reset");
        expect_bit(parity_err_flag, 1'b0, "R1 flag in reset");
        rst_n  = 1'b1;
        mon_en = 1'b1;
        idle(2);

        // 32-bit transfer: good address, good data, then two bad data back to back
        tick(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 64'h0000_0000_1000_2000, 8'h07, 1'b0, 1'b0, 1'b0, "R2 good address");
        tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0000_0000_DEAD_BEEF, 8'h00, 1'b0, 1'b0, 1'b0, "R2 good data");
        tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0000_0000_1234_5678, 8'h03, 1'b1, 1'b0, 1'b0, "R3 bad data");
        tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0000_0000_FFFF_0001, 8'h0F, 1'b1, 1'b0, 1'b0, "R3 back-to-back bad data");
        tick(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0F0F_0F0F, 8'h00, 1'b0, 1'b0, 1'b0, "R2 good last data");
        idle(3);
        expect_bit(parity_err_flag, 1'b1, "R9 flag after data error");
        clear_flag();

        // wait states with bad parity are not checked
        tick(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 64'h0000_0000_2000_0000, 8'h06, 1'b0, 1'b0, 1'b0, "R6 address");
        tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 64'h0000_0000_AAAA_5555, 8'h00, 1'b1, 1'b0, 1'b0, "R6 target wait");
        tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0000_0000_5555_AAAA, 8'h00, 1'b1, 1'b0, 1'b0, "R6 initiator wait");
        tick(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_0001, 8'h00, 1'b0, 1'b0, 1'b0, "R6 completed phase");
        idle(3);
        expect_bit(parity_err_flag, 1'b0, "R6 flag untouched by wait states");

        // response enable off: no pulse, flag still set
        cmd_perr_resp = 1'b0;
        idle(1);
        tick(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 64'h0000_0000_3000_0000, 8'h07, 1'b0, 1'b0, 1'b0, "R4 address");
        tick(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0000_0000_CAFE_F00D, 8'h00, 1'b1, 1'b0, 1'b0, "R4 bad data masked");
        idle(3);
        expect_bit(parity_err_flag, 1'b1, "R9 flag set with enable off");
        cmd_perr_resp = 1'b1;
        clear_flag();

        // address parity errors
        tick(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 64'h0000_0000_4000_0010, 8'h06, 1'b1, 1'b0, 1'b0, "R5 bad address");
        tick(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_00FF, 8'h00, 1'b0, 1'b0, 1'b0, "R5 data after address");
        idle(3);
        cmd_serr_en = 1'b0;
        idle(1);
        tick(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 64'h0000_0000_4000_0020, 8'h06, 1'b1, 1'b0, 1'b0, "R5 bad address masked");
        tick(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_0F00, 8'h00, 1'b0, 1'b0, 1'b0, "R5 data after address");
        idle(3);
        expect_bit(parity_err_flag, 1'b1, "R9 flag after address error");
        cmd_serr_en = 1'b1;
        clear_flag();

        // 32-bit request: upper lane ignored
        tick(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 64'h0000_0000_5000_0000, 8'h07, 1'b0, 1'b0, 1'b0, "R8 address");
        tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 64'h1357_9BDF_0000_1111, 8'hA0, 1'b0, 1'b1, 1'b0, "R8 bad upper lane ignored");
        tick(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64'hFFFF_FFFF_0000_2222, 8'h50, 1'b0, 1'b1, 1'b0, "R8 bad upper lane ignored");
        idle(3);
        expect_bit(parity_err_flag, 1'b0, "R8 flag untouched by upper lane");

        // 64-bit request acknowledged: upper lane checked
        tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 64'h0000_0000_6000_0000, 8'h07, 1'b0, 1'b0, 1'b0, "R7 address");
        tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h2468_ACE0_0000_3333, 8'hC0, 1'b0, 1'b1, 1'b1, "R7 bad upper lane");
        tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0101_0101_0000_4444, 8'h30, 1'b0, 1'b0, 1'b1, "R7 good wide phase");
        tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h8000_0000_0000_5555, 8'h10, 1'b1, 1'b0, 1'b1, "R7 bad lower lane in wide");
        idle(3);
        expect_bit(parity_err_flag, 1'b1, "R9 flag after wide error");
        clear_flag();

        // 64-bit requested but target answers 32-bit
        tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 64'h0000_0000_7000_0000, 8'h07, 1'b0, 1'b0, 1'b0, "R8 address");
        tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 64'h7777_0000_0000_6666, 8'hF0, 1'b0, 1'b1, 1'b0, "R8 upper lane ignored on 32-bit ack");
        tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0000_8888_0000_7777, 8'h20, 1'b0, 1'b1, 1'b0, "R8 upper lane ignored on 32-bit ack");
        idle(3);
        expect_bit(parity_err_flag, 1'b0, "R8 flag untouched on 32-bit ack");

        // reset discards a pending pulse
        mon_en = 1'b0;
        sbq.delete();
        tick(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_0003, 8'h00, 1'b1, 1'b0, 1'b0, "R1 bad data before reset");
        @(negedge clk);
        par_lo  = nxt_lo;
        rst_n   = 1'b0;
        irdy_n  = 1'b1;
        trdy_n  = 1'b1;
        devsel_n = 1'b1;
        @(negedge clk);
        expect_bit(dperr_n, 1'b1, "R1 dperr_n after reset");
        expect_bit(parity_err_flag, 1'b0, "R1 flag after reset");
        rst_n = 1'b1;
        @(negedge clk);
        expect_bit(dperr_n, 1'b1, "R1 dperr_n after release");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule